// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Controller

This block routes sixteen single-bit data lanes to sixteen output lanes through a full non-blocking crosspoint. Each output has its own 16-to-1 selector. Every selector is steered by one entry of an active routing bank. A second routing bank, the staging bank, is written one output at a time through a small control port. A single transfer strobe then copies the whole staging bank into the active bank at once. New routes can therefore be prepared while traffic keeps flowing on the current map.

The control port has an output-lane address, an input-lane address, a write strobe, a transfer strobe and a preset strobe. All five are treated as asynchronous. Each passes through a two-flop synchronizer before use, and the strobes act on their synchronized rising edges. When the write strobe and the transfer strobe are tied together, every write reaches the outputs at once. The preset strobe loads one of two fixed maps into both banks. With the transfer line low it loads the all-from-lane-0 map. With the transfer line high it loads the lane-n-to-lane-n map.

Top module: `xpt_switch_ctrl`

## Requirements
- R1: Any output lane may select any input lane, and several output lanes may select the same input lane at the same time.
- R2: A rising edge on `ctl_load` writes `ctl_in_addr` into the staging entry numbered by `ctl_out_addr`. A control level first sampled at clock edge k reaches the banks at edge k+2 and the outputs at edge k+3.
- R3: A rising edge on `ctl_apply` copies all staging entries into the active bank in the same clock. Only the active bank steers the selectors.
- R4: Writing the staging bank without a transfer leaves every output unchanged.
- R5: During a transfer, an output whose selected input is unchanged keeps passing data every cycle without interruption.
- R6: If the write edge and the transfer edge are seen in the same cycle, the active bank receives the newly written value.
- R7: While the synchronized `ctl_preset` is high and the synchronized `ctl_apply` is low, both banks are forced to select input 0 for every output.
- R8: While the synchronized `ctl_preset` is high and the synchronized `ctl_apply` is high, both banks are forced so that output n selects input n.
- R9: A transfer after a preset, with no writes in between, reapplies the same preset map.
- R10: While `rst_n` is low at a clock edge, all outputs are 0 and both banks hold the all-from-input-0 map.
- R11: Each output equals the selected input as sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_out_addr | input | SEL_W | Output lane whose staging entry is written |
| ctl_in_addr | input | SEL_W | Input lane number stored in that entry |
| ctl_load | input | 1 | Write strobe, acts on its rising edge |
| ctl_apply | input | 1 | Transfer strobe; its level also chooses the preset map |
| ctl_preset | input | 1 | Forces a preset map into both banks while high |
| data_in | input | N_PORTS | Input lanes |
| data_out | output | N_PORTS | Registered output lanes |

## Verification
Fresh random data is driven on every input lane in every cycle. A wrong selector, a dropped cycle or a stale route therefore shows up on the output lane at once. The bench runs a reversed map, a map in which several outputs share one input next to outputs whose routes do not change, single writes with the two strobes tied together, and both preset maps followed by a bare transfer. Together these separate a missing double buffer, a stale value on a same-cycle write, a swapped preset choice and a glitch on an unchanged route.

// File: rtl/xpt_pkg.sv
// Package: shared types for the crosspoint switch controller.
// Assumes: nothing beyond the standard language.
package xpt_pkg;
    // Preset map choice, taken from the synchronized transfer line level
    typedef enum logic {
        MAP_BCAST = 1'b0,
        MAP_PASS  = 1'b1
    } preset_e;
endpackage

// File: rtl/xpt_sync.sv
// Module: xpt_sync
// Brings W asynchronous control bits into the clock domain through two flops.
// Assumes: each bit is quasi-static for at least two clocks around a change.
module xpt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl
);
    logic [W-1:0] stage1;

    // Two-flop chain per bit, cleared by the synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            lvl    <= '0;
        end else begin
            stage1 <= raw;
            lvl    <= stage1;
        end
    end
endmodule

// File: rtl/xpt_edge.sv
// Module: xpt_edge
// Produces a one-cycle pulse for each rising edge of W synchronized levels.
// Assumes: the inputs are already in the clock domain.
module xpt_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // A pulse where the level is high now and was low before
    always_comb rise = lvl & ~prev;

    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> !rise[0])
        else $error("edge pulse lasted more than one cycle");
endmodule

// File: rtl/xpt_prog_bank.sv
// Module: xpt_prog_bank
// Staging bank: one SEL_W entry per output lane. It is written through a
// one-of-N decode or forced to a preset map. It also exposes its next-state
// value, so a transfer in the same cycle sees a fresh write.
// Assumes: wr_en is a single-cycle pulse; preset takes priority over writes.
module xpt_prog_bank
    import xpt_pkg::*;
#(
    parameter int N_PORTS = 16,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_addr,
    input  logic [SEL_W-1:0]              wr_val,
    input  logic                          preset,
    input  preset_e                       preset_map,
    output logic [N_PORTS-1:0][SEL_W-1:0] prog_next,
    output logic [N_PORTS-1:0][SEL_W-1:0] prog_q
);
    for (genvar i = 0; i < N_PORTS; i++) begin : g_entry
        logic hit;
        logic [SEL_W-1:0] preset_val;

        // One-of-N decode of the write address
        always_comb hit = wr_en && (wr_addr == SEL_W'(i));

        // Preset value for this entry: lane i or lane 0
        always_comb preset_val = (preset_map == MAP_PASS) ? SEL_W'(i) : '0;

        // Next-state selection: preset, then write, then hold
        always_comb begin
            if (preset)   prog_next[i] = preset_val;
            else if (hit) prog_next[i] = wr_val;
            else          prog_next[i] = prog_q[i];
        end

        // Entry register, cleared to input 0 by reset
        always_ff @(posedge clk) begin
            if (!rst_n) prog_q[i] <= '0;
            else        prog_q[i] <= prog_next[i];
        end
    end

    p_prog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !preset) |=> $stable(prog_q))
        else $error("staging bank changed without a write");

    p_prog_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && preset_map == MAP_PASS) |=> (prog_q[N_PORTS-1] == SEL_W'(N_PORTS-1)))
        else $error("pass-through preset not stored in staging bank");
endmodule

// File: rtl/xpt_active_bank.sv
// Module: xpt_active_bank
// Active bank: holds the selector value for every output lane. It takes the
// staging bank's next state on a transfer or a preset.
// Assumes: prog_next already carries the preset map while preset is high.
module xpt_active_bank #(
    parameter int N_PORTS = 16,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          apply,
    input  logic                          preset,
    input  logic [N_PORTS-1:0][SEL_W-1:0] prog_next,
    output logic [N_PORTS-1:0][SEL_W-1:0] act_q
);
    // Parallel copy of all entries on a transfer or a preset
    always_ff @(posedge clk) begin
        if (!rst_n)                act_q <= '0;
        else if (apply || preset)  act_q <= prog_next;
    end

    p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !preset) |=> $stable(act_q))
        else $error("active bank changed without a transfer");

    p_act_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && prog_next[N_PORTS-1] == '0) |=> (act_q[N_PORTS-1] == '0))
        else $error("broadcast preset not applied");
endmodule

// File: rtl/xpt_mux_plane.sv
// Module: xpt_mux_plane
// One N-to-1 selector per output lane, followed by an output register.
// Assumes: selector values are below N_PORTS.
module xpt_mux_plane #(
    parameter int N_PORTS = 16,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PORTS-1:0]            din,
    input  logic [N_PORTS-1:0][SEL_W-1:0] sel,
    output logic [N_PORTS-1:0]            dout
);
    for (genvar o = 0; o < N_PORTS; o++) begin : g_lane
        // Select and register one output lane
        always_ff @(posedge clk) begin
            if (!rst_n) dout[o] <= 1'b0;
            else        dout[o] <= din[sel[o]];
        end
    end

    p_lane0_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout[0] == $past(din[sel[0]])))
        else $error("lane 0 latency or selection wrong");
endmodule

// File: rtl/xpt_switch_ctrl.sv
// Module: xpt_switch_ctrl (top)
// Double-buffered crosspoint: synchronizes the control port, detects strobe
// edges, stages routes, transfers them and drives the registered outputs.
// Assumes: control inputs are asynchronous and held for at least two clocks.
module xpt_switch_ctrl
    import xpt_pkg::*;
#(
    parameter int N_PORTS = 16,
    parameter int SEL_W   = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   ctl_out_addr,
    input  logic [SEL_W-1:0]   ctl_in_addr,
    input  logic               ctl_load,
    input  logic               ctl_apply,
    input  logic               ctl_preset,
    input  logic [N_PORTS-1:0] data_in,
    output logic [N_PORTS-1:0] data_out
);
    localparam int CTL_W = 2 * SEL_W + 3;

    logic [CTL_W-1:0] ctl_raw, ctl_lvl;
    logic [SEL_W-1:0] oa_s, ia_s;
    logic             load_s, apply_s, preset_s;
    logic [1:0]       strobe_rise;
    logic             load_rise, apply_rise;
    preset_e          map_sel;
    logic [N_PORTS-1:0][SEL_W-1:0] prog_next, prog_q, act_q;

    // Bundle the control port for a common synchronizer
    always_comb ctl_raw = {ctl_preset, ctl_apply, ctl_load, ctl_out_addr, ctl_in_addr};

    xpt_sync #(.W(CTL_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(ctl_raw), .lvl(ctl_lvl)
    );

    // Unpack the synchronized bundle
    always_comb {preset_s, apply_s, load_s, oa_s, ia_s} = ctl_lvl;

    xpt_edge #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl({apply_s, load_s}), .rise(strobe_rise)
    );

    // Name the strobe pulses and the preset map choice
    always_comb begin
        load_rise  = strobe_rise[0];
        apply_rise = strobe_rise[1];
        map_sel    = apply_s ? MAP_PASS : MAP_BCAST;
    end

    xpt_prog_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .wr_en(load_rise), .wr_addr(oa_s),
        .wr_val(ia_s), .preset(preset_s), .preset_map(map_sel),
        .prog_next(prog_next), .prog_q(prog_q)
    );

    xpt_active_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_act (
        .clk(clk), .rst_n(rst_n), .apply(apply_rise), .preset(preset_s),
        .prog_next(prog_next), .act_q(act_q)
    );

    xpt_mux_plane #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .din(data_in), .sel(act_q), .dout(data_out)
    );

    p_tied_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rise && apply_rise && !preset_s) |=> (act_q[$past(oa_s)] == $past(ia_s)))
        else $error("same-cycle transfer took a stale entry");

    p_transfer_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_rise && !load_rise && !preset_s) |=> (act_q == $past(prog_q)))
        else $error("transfer did not copy the staging bank");
endmodule

// File: tb/xpt_switch_ctrl_tb.sv
module xpt_switch_ctrl_tb;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] oa = '0, ia = '0;
    logic ld = 1'b0, ap = 1'b0, pr = 1'b0;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;

    int vectors = 0, miscompares = 0, cycles = 0;
    string tag = "R10";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xpt_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_out_addr(oa), .ctl_in_addr(ia),
        .ctl_load(ld), .ctl_apply(ap), .ctl_preset(pr),
        .data_in(din), .data_out(dout)
    );

    // Behavioural reference: control sampled twice, then acted on
    int m_prog[N], m_act[N];
    logic [10:0] m_s1 = '0, m_s2 = '0;
    bit m_ld_prev = 0, m_ap_prev = 0;
    logic [N-1:0] exp_out = '0;

    always @(posedge clk) begin
        logic [N-1:0] nxt;
        bit ldr, apr, pre, mode;
        if (!rst_n) begin
            for (int n = 0; n < N; n++) begin m_prog[n] = 0; m_act[n] = 0; end
            m_s1 = '0; m_s2 = '0; m_ld_prev = 0; m_ap_prev = 0; exp_out = '0;
        end else begin
            for (int n = 0; n < N; n++) nxt[n] = din[m_act[n]];
            pre  = m_s2[10];
            mode = m_s2[9];
            ldr  = m_s2[8] && !m_ld_prev;
            apr  = m_s2[9] && !m_ap_prev;
            if (pre) begin
                for (int n = 0; n < N; n++) begin
                    m_prog[n] = mode ? n : 0; m_act[n] = m_prog[n];
                end
            end else begin
                if (ldr) m_prog[int'(m_s2[7:4])] = int'(m_s2[3:0]);
                if (apr) for (int n = 0; n < N; n++) m_act[n] = m_prog[n];
            end
            m_ld_prev = m_s2[8]; m_ap_prev = m_s2[9];
            m_s2 = m_s1;
            m_s1 = {pr, ap, ld, oa, ia};
            exp_out = nxt;
        end
    end

    // Compare away from the active edge, every cycle
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (dout !== exp_out) begin
                miscompares++;
                $display("FAIL %s: data_out=%h expected=%h at cycle %0d", tag, dout, exp_out, cycles);
            end
            din <= N'($urandom);
        end
    end

    task automatic report();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
            report();
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stage(int o, int i);
        @(negedge clk); oa = 4'(o); ia = 4'(i); ld = 1'b1;
        idle(2); ld = 1'b0; idle(3);
    endtask

    task automatic transfer();
        @(negedge clk); ap = 1'b1; idle(2); ap = 1'b0; idle(5);
    endtask

    task automatic tied(int o, int i);
        @(negedge clk); oa = 4'(o); ia = 4'(i); ld = 1'b1; ap = 1'b1;
        idle(2); ld = 1'b0; ap = 1'b0; idle(5);
    endtask

    task automatic preset(bit mode);
        @(negedge clk); ap = mode; idle(3); pr = 1'b1; idle(3); pr = 1'b0; idle(3); ap = 1'b0; idle(5);
    endtask

    initial begin
        tag = "R10"; idle(5); rst_n = 1'b1; idle(10);   // reset, then all from lane 0
        tag = "R4";  for (int o = 0; o < N; o++) stage(o, N - 1 - o);  // R2 staging, outputs hold
        tag = "R3";  transfer();  idle(10);
        tag = "R1";  stage(0, 5); stage(3, 5); stage(9, 5); stage(2, 13);
        tag = "R5";  transfer();  idle(10);
        tag = "R6";  tied(4, 11); tied(4, 4); tied(15, 5);
        tag = "R8";  preset(1'b1); idle(10);
        tag = "R9";  transfer();  idle(10);
        tag = "R7";  preset(1'b0); idle(10);
        tag = "R9";  transfer();  idle(5);
        tag = "R11"; for (int k = 0; k < 8; k++) tied(k * 2, 15 - k); idle(20);
        tag = "R10"; @(negedge clk); rst_n = 1'b0; idle(4); rst_n = 1'b1; idle(10);
        report();
    end
endmodule